// File: doc/BRIEF.md
# Receive Pause Hold Controller

This block keeps the receive side of a link in a paused state once a flow-control pause frame has been decoded. It tracks nine pause classes: eight priority classes and one class for link-wide (global) pause. Each class has its own small state machine and a 16-bit quanta timer. When a frame arrives for an enabled class, that class raises its bit on the request bus. It can then wait for user logic to acknowledge by raising the matching acknowledge bit. After that it counts the received quanta down and drops the request when the count runs out.

The frame decoder presents a one-cycle strobe with a class index and the quanta value. A free-running quanta tick marks each pause quantum. A single control bit chooses whether classes wait for an acknowledge edge before counting. The request bus carries a 3-bit port id, which is a parameter. Acknowledges are accepted only when their 3-bit id matches that parameter.

Top module: `rx_pause_hold`

## Requirements
- R1: After reset every request bit is 0. `req_port` always equals the `PORT_ID` parameter (default 0).
- R2: A frame strobe for a class whose enable bit is 0 while that class is idle is discarded, and that request bit stays 0.
- R3: A frame strobe for an enabled idle class sets its request bit on the next cycle and loads its timer with the quanta. Class index 0..7 maps to request bits 7:0 (priority), index 8 maps to bit 8 (global), and indexes 9..15 are ignored.
- R4: When `ack_check` is 1 at the moment a class is loaded from idle, the class holds its request without counting until a rising edge appears on its own acknowledge bit.
- R5: When `ack_check` is 0 at that moment, the class starts counting at once without any acknowledge.
- R6: The timer moves only on cycles with `quanta_tick` high. A quanta of N >= 1 keeps the request high for N ticks, and a quanta of 0 keeps it for one tick. The request bit is 0 from the cycle after the last tick.
- R7: A frame for a class that is already active reloads its timer with the new quanta and leaves the class in its current step. A reload on the same cycle as a tick takes priority over the tick.
- R8: Clearing an active class's enable bit does not shorten its sequence. Enable is examined only in idle.
- R9: An acknowledge bit that stays high after its request falls, or that rises while its class is idle, is not treated as a rising edge by a later wait.
- R10: An acknowledge edge is accepted only when `ack_port` equals `PORT_ID`.
- R11: Classes are independent. A frame, tick count or acknowledge for one class does not change another class's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a pause frame has been decoded |
| frm_class | input | 4 | Class index of the frame (8 = global) |
| frm_quanta | input | 16 | Pause quanta carried by the frame |
| class_en | input | 9 | Per-class enable, examined only in idle |
| ack_check | input | 1 | 1: wait for an acknowledge edge before counting |
| ack_bus | input | 9 | Per-class acknowledge from user logic |
| ack_port | input | 3 | Port id accompanying the acknowledge bus |
| quanta_tick | input | 1 | One-cycle strobe per pause quantum |
| req_bus | output | 9 | Per-class pause request |
| req_port | output | 3 | Port id accompanying the request bus |

## Verification
The countdown is exercised with quanta of 0, 1 and 3, with and without gaps between ticks. These cases separate an off-by-one expiry from correct N-tick holding. The acknowledge path is tried in several ways: a clean rising edge, no edge at all, a level held over from an earlier sequence, a pulse during idle, and a pulse under a foreign port id. Only the clean rising edge may start the count. Reload, enable removal and frames to two classes run in parallel show that reloads restart the count and that the classes are independent. A global-class frame and an out-of-range index check the bit mapping.

// File: rtl/rx_pause_pkg.sv
package rx_pause_pkg;
    localparam int NUM_CLASSES = 9;
    localparam int QUANTA_W    = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2
    } pcls_state_e;

    typedef struct packed {
        pcls_state_e         state;
        logic [QUANTA_W-1:0] timer;
        logic                ack_prev;
    } pcls_reg_t;
endpackage

// File: rtl/rx_pause_class.sv
module rx_pause_class
    import rx_pause_pkg::*;
#(
    parameter int QW = QUANTA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [QW-1:0] quanta,
    input  logic          en,
    input  logic          ack_check,
    input  logic          ack_in,
    input  logic          tick,
    output logic          req
);
    typedef struct packed {
        pcls_state_e   state;
        logic [QW-1:0] timer;
        logic          ack_prev;
    } cls_t;

    cls_t r_q, r_d;
    logic ack_edge;

    assign ack_edge = ack_in && !r_q.ack_prev;

    always_comb begin
        r_d          = r_q;
        r_d.ack_prev = ack_in;
        unique case (r_q.state)
            ST_IDLE: begin
                if (hit && en) begin
                    r_d.timer = quanta;
                    r_d.state = ack_check ? ST_WAIT : ST_COUNT;
                end
            end
            ST_WAIT: begin
                if (hit) r_d.timer = quanta;
                if (ack_edge) r_d.state = ST_COUNT;
            end
            ST_COUNT: begin
                if (hit) begin
                    r_d.timer = quanta;
                end else if (tick) begin
                    if (r_q.timer <= QW'(1)) begin
                        r_d.timer = '0;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.timer = r_q.timer - QW'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.timer    <= '0;
            r_q.ack_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req = (r_q.state != ST_IDLE);

    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && hit && !en) |=> !req);

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && hit && en) |=> (req && r_q.timer == $past(quanta)));

    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && !(ack_in && !r_q.ack_prev)) |=> (r_q.state == ST_WAIT));

    p_no_tick_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_COUNT && !tick && !hit) |=> ($stable(r_q.timer) && req));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE && hit) |=> (req && r_q.timer == $past(quanta)));
endmodule

// File: rtl/rx_pause_hold.sv
module rx_pause_hold
    import rx_pause_pkg::*;
#(
    parameter int          NCLS    = NUM_CLASSES,
    parameter int          QW      = QUANTA_W,
    parameter logic [2:0]  PORT_ID = 3'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_valid,
    input  logic [3:0]      frm_class,
    input  logic [QW-1:0]   frm_quanta,
    input  logic [NCLS-1:0] class_en,
    input  logic            ack_check,
    input  logic [NCLS-1:0] ack_bus,
    input  logic [2:0]      ack_port,
    input  logic            quanta_tick,
    output logic [NCLS-1:0] req_bus,
    output logic [2:0]      req_port
);
    logic port_match;
    assign port_match = (ack_port == PORT_ID);
    assign req_port   = PORT_ID;

    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        logic hit_i;
        assign hit_i = frm_valid && (frm_class == 4'(i));

        rx_pause_class #(.QW(QW)) u_cls (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit_i),
            .quanta    (frm_quanta),
            .en        (class_en[i]),
            .ack_check (ack_check),
            .ack_in    (ack_bus[i] && port_match),
            .tick      (quanta_tick),
            .req       (req_bus[i])
        );
    end

    p_reset_r1: assert property (@(posedge clk) $past(!rst_n) |-> (req_bus == '0));

    p_bad_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_class >= 4'(NCLS) && req_bus == '0 && !quanta_tick) |=> (req_bus == '0));
endmodule

// File: tb/rx_pause_hold_tb.sv
module rx_pause_hold_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [3:0]  frm_class = '0;
    logic [15:0] frm_quanta = '0;
    logic [8:0]  class_en = '1;
    logic        ack_check = 1'b0;
    logic [8:0]  ack_bus = '0;
    logic [2:0]  ack_port = '0;
    logic        quanta_tick = 1'b0;
    logic [8:0]  req_bus;
    logic [2:0]  req_port;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_pause_hold dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_class(frm_class),
        .frm_quanta(frm_quanta), .class_en(class_en), .ack_check(ack_check),
        .ack_bus(ack_bus), .ack_port(ack_port), .quanta_tick(quanta_tick),
        .req_bus(req_bus), .req_port(req_port)
    );

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic frame(int cls, int q);
        frm_valid = 1'b1; frm_class = 4'(cls); frm_quanta = 16'(q);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            quanta_tick = 1'b1;
            @(negedge clk);
        end
        quanta_tick = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset req", req_bus, 9'h000);
        check("R1 port id", {6'd0, req_port}, 9'h000);
    endtask

    task automatic t_disabled;
        class_en = 9'h1FE;
        frame(0, 5);
        check("R2 disabled frame", req_bus, 9'h000);
        class_en = '1;
    endtask

    task automatic t_count;
        ack_check = 1'b0;
        frame(1, 3);
        check("R3 load", req_bus, 9'h002);
        ticks(1); idle(3);
        check("R6 gap no move", req_bus, 9'h002);
        ticks(1);
        check("R6 after 2 ticks", req_bus, 9'h002);
        ticks(1);
        check("R6 expire 3 ticks", req_bus, 9'h000);
        frame(1, 0);
        check("R5 zero load", req_bus, 9'h002);
        ticks(1);
        check("R6 zero one tick", req_bus, 9'h000);
        frame(1, 1);
        ticks(1);
        check("R6 one one tick", req_bus, 9'h000);
    endtask

    task automatic t_global_range;
        frame(8, 2);
        check("R3 global bit8", req_bus, 9'h100);
        ticks(2);
        check("R6 global expire", req_bus, 9'h000);
        frame(12, 4);
        check("R3 bad index", req_bus, 9'h000);
    endtask

    task automatic t_ack;
        ack_check = 1'b1;
        frame(3, 2);
        ack_check = 1'b0;
        ticks(5);
        check("R4 wait no edge", req_bus, 9'h008);
        ack_port = 3'd5; ack_bus[3] = 1'b1; @(negedge clk);
        ack_bus[3] = 1'b0; ack_port = 3'd0; @(negedge clk);
        ticks(4);
        check("R10 foreign port", req_bus, 9'h008);
        ack_bus[3] = 1'b1; @(negedge clk);
        ticks(1);
        check("R4 edge counting", req_bus, 9'h008);
        ticks(1);
        check("R4 expire after ack", req_bus, 9'h000);
        ack_check = 1'b1;
        frame(3, 1);
        ticks(4);
        check("R9 held ack no edge", req_bus, 9'h008);
        ack_bus[3] = 1'b0; @(negedge clk);
        ack_bus[3] = 1'b1; @(negedge clk);
        ticks(1);
        check("R9 fresh edge", req_bus, 9'h000);
        ack_bus[3] = 1'b0; @(negedge clk);
        ack_bus[3] = 1'b1; @(negedge clk);
        frame(3, 1);
        ticks(3);
        check("R9 idle edge ignored", req_bus, 9'h008);
        ack_bus[3] = 1'b0; @(negedge clk);
        ack_bus[3] = 1'b1; @(negedge clk);
        ack_bus[3] = 1'b0;
        ticks(1);
        check("R9 cleanup", req_bus, 9'h000);
        ack_check = 1'b0;
    endtask

    task automatic t_reload_enable;
        frame(4, 2);
        ticks(1);
        frm_valid = 1'b1; frm_class = 4'd4; frm_quanta = 16'd3; quanta_tick = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0; quanta_tick = 1'b0;
        class_en[4] = 1'b0;
        ticks(2);
        check("R7 R8 reload held", req_bus, 9'h010);
        ticks(1);
        check("R7 reload expire", req_bus, 9'h000);
        class_en[4] = 1'b1;
    endtask

    task automatic t_indep;
        frame(5, 1);
        frame(6, 3);
        check("R11 both active", req_bus, 9'h060);
        ticks(1);
        check("R11 one expires", req_bus, 9'h040);
        ticks(2);
        check("R11 other expires", req_bus, 9'h000);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_count();
        t_global_range();
        t_ack();
        t_reload_enable();
        t_indep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule